// File: doc/BRIEF.md
# Double-Buffered Blit Parameter Registers

This block holds the geometry and mode parameters for a 2D drawing engine in two banks. The host writes a front bank through a simple register write port. A start strobe copies the front bank into a back bank, and the engine reads only from the back bank. The host can therefore prepare the next primitive while the current one is still being drawn. If the host issues a start while the engine is busy, the copy waits until the engine signals completion, and a pending flag marks that queued primitive. Host writes that arrive while a primitive is queued are discarded, and a sticky error flag records them.

Each front register carries a flag that records whether the host wrote it since the last copy. A register the host left alone is not copied from the front bank. Its next value is instead derived from the back bank. In glyph mode the destination X advances by the width. In bitmap mode the destination Y and source Y move up or down by the height. In vector mode the position and error term carry over as the engine last reported them. This lets runs of text or stacked bitmaps be drawn with very few register writes.

Top module: `blit_param_bank`

## Requirements
- R1: After reset, every back-bank output is zero, `eng_go` is low, and `status` is 0. The status bits are: bit 0 busy, bit 1 dropped-write error, bit 2 pending.
- R2: The register addresses are: 0 destination X, 1 destination Y, 2 source Y, 3 width, 4 height, 5 error term, 6 mode. A start while idle copies every written front register into the back bank on the same clock edge. On that edge `eng_go` pulses for one cycle and busy is set.
- R3: A start while busy and without `eng_done` sets status bit 2. The back bank stays unchanged until `eng_done`. On the edge of `eng_done` the deferred copy takes place, bit 2 clears, busy stays set, and `eng_go` pulses.
- R4: A host write while bit 2 is set changes no front register and sets status bit 1. Bit 1 then stays set until reset.
- R5: Mode bit 0 set selects glyph source and clear selects bitmap source. With mode bit 2 clear and destination X not written, the next destination X is computed as follows. In glyph mode it is the old back value plus the old back width, modulo 2^W. In bitmap mode it is the old back value. The mode used for this rule is the newly copied mode.
- R6: With destination Y not written and bitmap mode, the next value is the old back value plus the old back height. When mode bit 1 is set, it is the old back value minus that height instead. The result is modulo 2^W. In glyph mode the value is unchanged.
- R7: With source Y not written, the value follows the same rule as R6: plus or minus the height in bitmap mode, unchanged in glyph mode.
- R8: With mode bit 2 set (vector), unwritten registers keep their back values. The strobe `eng_wb` loads the back destination X, destination Y and error term from the engine, so that the next vector continues from there.
- R9: Width, height, error term and mode, when not written, keep their back values. In bitmap mode, non-vector, the error term is also held.
- R10: The written flags clear at every copy. A second start with no writes in between applies the carry rules and does not reuse the old front values.
- R11: `eng_done` with nothing pending clears busy on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | W | Write data |
| start | input | 1 | Start-operation strobe |
| eng_done | input | 1 | Engine finished the current operation |
| eng_wb | input | 1 | Engine write-back of vector position and error |
| eng_wb_x | input | W | Next vector X from the engine |
| eng_wb_y | input | W | Next vector Y from the engine |
| eng_wb_err | input | W | Next error term from the engine |
| eng_go | output | 1 | One-cycle pulse: back bank just loaded |
| status | output | 3 | {pending, dropped-write error, busy} |
| dst_x | output | W | Back-bank destination X |
| dst_y | output | W | Back-bank destination Y |
| src_y | output | W | Back-bank source Y |
| width | output | W | Back-bank width |
| height | output | W | Back-bank height |
| init_err | output | W | Back-bank error term |
| mode | output | W | Back-bank mode |

## Verification
Every result is registered once. The back bank, `eng_go` and all status bits change on the same edge that samples the start, `eng_done`, write or write-back. Inputs are driven on the falling edge and held for exactly one rising edge. The checks read the outputs on the next falling edge, half a cycle after the one register stage. A deferred copy is checked on the falling edge after `eng_done` and not after the start. Before that point, the bench confirms that the back bank still shows the old primitive.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NREG    = 7;
  localparam int IX_DSTX = 0;
  localparam int IX_DSTY = 1;
  localparam int IX_SRCY = 2;
  localparam int IX_WID  = 3;
  localparam int IX_HGT  = 4;
  localparam int IX_ERR  = 5;
  localparam int IX_MODE = 6;
  localparam int MB_GLYPH = 0;
  localparam int MB_UP    = 1;
  localparam int MB_VEC   = 2;
  typedef logic [2:0] reg_addr_t;
endpackage

// File: rtl/bp_master_bank.sv
module bp_master_bank
  import blit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  reg_addr_t                wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic                     accept,
  input  logic                     clr_flags,
  output logic [NREG-1:0][W-1:0]   mst_q,
  output logic [NREG-1:0]          flag_q
);
  logic [NREG-1:0][W-1:0] mst_d;
  logic [NREG-1:0]        flag_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    always_comb begin
      hit       = wr_en && accept && (wr_addr == reg_addr_t'(i));
      mst_d[i]  = hit ? wr_data : mst_q[i];
      flag_d[i] = hit ? 1'b1 : (clr_flags ? 1'b0 : flag_q[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mst_q[i]  <= '0;
        flag_q[i] <= 1'b0;
      end else begin
        mst_q[i]  <= mst_d[i];
        flag_q[i] <= flag_d[i];
      end
    end
  end

  AST_DROP_KEEPS_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(mst_q)); // R4
endmodule

// File: rtl/bp_seq.sv
module bp_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic eng_done,
  input  logic wr_en,
  output logic xfer,
  output logic busy_q,
  output logic pend_q,
  output logic err_q
);
  logic busy_d, pend_d, err_d;

  always_comb begin
    xfer   = (pend_q && eng_done) ||
             (start && !pend_q && (!busy_q || eng_done));
    pend_d = pend_q ? !eng_done : (start && busy_q && !eng_done);
    busy_d = xfer ? 1'b1 : (eng_done ? 1'b0 : busy_q);
    err_d  = err_q || (wr_en && pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_q); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R4
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !pend_q && !start) |=> !busy_q); // R11
endmodule

// File: rtl/bp_advance.sv
module bp_advance
  import blit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NREG-1:0][W-1:0] slv,
  input  logic [NREG-1:0][W-1:0] mst,
  input  logic [NREG-1:0]        flag,
  output logic [NREG-1:0][W-1:0] nxt
);
  logic [W-1:0]           mode_new;
  logic                   glyph, up, vec;
  logic [NREG-1:0][W-1:0] carry;

  function automatic logic [W-1:0] vstep(input logic [W-1:0] base,
                                         input logic [W-1:0] h,
                                         input logic dn);
    return dn ? (base - h) : (base + h);
  endfunction

  always_comb begin
    mode_new = flag[IX_MODE] ? mst[IX_MODE] : slv[IX_MODE];
    glyph    = mode_new[MB_GLYPH];
    up       = mode_new[MB_UP];
    vec      = mode_new[MB_VEC];
    carry    = slv;
    if (!vec) begin
      if (glyph) begin
        carry[IX_DSTX] = slv[IX_DSTX] + slv[IX_WID];
      end else begin
        carry[IX_DSTY] = vstep(slv[IX_DSTY], slv[IX_HGT], up);
        carry[IX_SRCY] = vstep(slv[IX_SRCY], slv[IX_HGT], up);
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign nxt[i] = flag[i] ? mst[i] : carry[i];
  end
endmodule

// File: rtl/blit_param_bank.sv
module blit_param_bank
  import blit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         eng_done,
  input  logic         eng_wb,
  input  logic [W-1:0] eng_wb_x,
  input  logic [W-1:0] eng_wb_y,
  input  logic [W-1:0] eng_wb_err,
  output logic         eng_go,
  output logic [2:0]   status,
  output logic [W-1:0] dst_x,
  output logic [W-1:0] dst_y,
  output logic [W-1:0] src_y,
  output logic [W-1:0] width,
  output logic [W-1:0] height,
  output logic [W-1:0] init_err,
  output logic [W-1:0] mode
);
  logic [1:0]             rst_sync;
  logic                   rst_i;
  logic                   xfer, busy_q, pend_q, err_q;
  logic [NREG-1:0][W-1:0] mst_q, adv, slv_q, slv_d;
  logic [NREG-1:0]        flag_q;
  logic                   go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  bp_seq u_seq (
    .clk(clk), .rst_n(rst_i), .start(start), .eng_done(eng_done),
    .wr_en(wr_en), .xfer(xfer), .busy_q(busy_q), .pend_q(pend_q), .err_q(err_q)
  );

  bp_master_bank #(.W(W)) u_front (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .accept(!pend_q), .clr_flags(xfer),
    .mst_q(mst_q), .flag_q(flag_q)
  );

  bp_advance #(.W(W)) u_adv (
    .slv(slv_q), .mst(mst_q), .flag(flag_q), .nxt(adv)
  );

  always_comb begin
    slv_d = slv_q;
    if (xfer) begin
      slv_d = adv;
    end else if (eng_wb) begin
      slv_d[IX_DSTX] = eng_wb_x;
      slv_d[IX_DSTY] = eng_wb_y;
      slv_d[IX_ERR]  = eng_wb_err;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      slv_q <= '0;
      go_q  <= 1'b0;
    end else begin
      slv_q <= slv_d;
      go_q  <= xfer;
    end
  end

  assign eng_go   = go_q;
  assign status   = {pend_q, err_q, busy_q};
  assign dst_x    = slv_q[IX_DSTX];
  assign dst_y    = slv_q[IX_DSTY];
  assign src_y    = slv_q[IX_SRCY];
  assign width    = slv_q[IX_WID];
  assign height   = slv_q[IX_HGT];
  assign init_err = slv_q[IX_ERR];
  assign mode     = slv_q[IX_MODE];

  AST_BACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_i)
    (!xfer && !eng_wb) |=> $stable(slv_q)); // R3
  AST_GO_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    eng_go |-> busy_q); // R2
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_go && !pend_q) |=> !eng_go); // R2
  AST_PEND_CLEAR_COPIES: assert property (@(posedge clk) disable iff (!rst_i)
    (pend_q && eng_done) |=> (eng_go && !pend_q)); // R3
endmodule

// File: tb/blit_param_bank_tb.sv
module blit_param_bank_tb_top;
  localparam int W = 6;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic start = 1'b0, eng_done = 1'b0, eng_wb = 1'b0;
  logic [W-1:0] eng_wb_x = '0, eng_wb_y = '0, eng_wb_err = '0;
  logic eng_go;
  logic [2:0] status;
  logic [W-1:0] dst_x, dst_y, src_y, width, height, init_err, mode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  blit_param_bank #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .eng_done(eng_done), .eng_wb(eng_wb),
    .eng_wb_x(eng_wb_x), .eng_wb_y(eng_wb_y), .eng_wb_err(eng_wb_err),
    .eng_go(eng_go), .status(status), .dst_x(dst_x), .dst_y(dst_y),
    .src_y(src_y), .width(width), .height(height), .init_err(init_err),
    .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic load(input int x, input int y, input int sy, input int w,
                      input int h, input int e, input int md);
    wr(0, x); wr(1, y); wr(2, sy); wr(3, w); wr(4, h); wr(5, e); wr(6, md);
    pulse_start();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 go", eng_go, 0);
    chk("R1 dst_x", dst_x, 0);
    chk("R1 mode", mode, 0);

    // R2 full load while idle
    load(3, 9, 17, 5, 6, 33, 0);
    chk("R2 go", eng_go, 1);
    chk("R2 busy", status, 1);
    chk("R2 dst_x", dst_x, 3);
    chk("R2 dst_y", dst_y, 9);
    chk("R2 src_y", src_y, 17);
    chk("R2 width", width, 5);
    chk("R2 height", height, 6);
    chk("R2 err", init_err, 33);
    @(negedge clk);
    chk("R2 go one cycle", eng_go, 0);
    pulse_done();
    chk("R11 idle", status, 0);

    // R5 R10 glyph sweep over all widths
    for (int w = 0; w < M; w++) begin
      int x;
      x = (w * 5 + 7) % M;
      load(x, 10, 20, w, 3, 7, 1);
      pulse_done();
      pulse_start();
      chk("R5 glyph dst_x", dst_x, (x + w) % M);
      chk("R6 glyph dst_y", dst_y, 10);
      chk("R7 glyph src_y", src_y, 20);
      chk("R9 width", width, w);
      pulse_done();
    end

    // R6 R7 R10 bitmap sweep over heights and both directions
    for (int dn = 0; dn < 2; dn++) begin
      for (int h = 0; h < M; h++) begin
        int y, sy;
        y  = (h * 3 + 1) % M;
        sy = (h * 7 + 2) % M;
        load(12, y, sy, 4, h, 9, dn * 2);
        pulse_done();
        pulse_start();
        chk("R5 bitmap dst_x", dst_x, 12);
        chk("R6 bitmap dst_y", dst_y, dn ? (y - h + M) % M : (y + h) % M);
        chk("R7 bitmap src_y", src_y, dn ? (sy - h + M) % M : (sy + h) % M);
        chk("R9 height/err", {height, init_err}, {W'(h), W'(9)});
        pulse_done();
      end
    end

    // R8 vector carry-over from engine write-back
    load(5, 6, 7, 8, 9, 10, 4);
    @(negedge clk);
    eng_wb = 1'b1; eng_wb_x = 11; eng_wb_y = 12; eng_wb_err = 13;
    @(negedge clk);
    eng_wb = 1'b0;
    chk("R8 wb x", dst_x, 11);
    pulse_done();
    pulse_start();
    chk("R8 vec dst_x", dst_x, 11);
    chk("R8 vec dst_y", dst_y, 12);
    chk("R8 vec err", init_err, 13);
    chk("R8 vec src_y", src_y, 7);
    chk("R9 mode", mode, 4);
    pulse_done();

    // R3 R4 deferred copy and dropped write
    load(1, 2, 3, 4, 5, 6, 0);
    wr(0, 40);
    pulse_start();
    chk("R3 pending", status, 5);
    chk("R3 no go", eng_go, 0);
    chk("R3 deferred dst_x", dst_x, 1);
    repeat (3) @(negedge clk);
    chk("R3 still held", dst_x, 1);
    wr(3, 33);
    chk("R4 err set", status, 7);
    pulse_done();
    chk("R3 copy on done", dst_x, 40);
    chk("R3 go on done", eng_go, 1);
    chk("R3 pending clear", status, 3);
    chk("R4 width kept", width, 4);
    chk("R6 carried dst_y", dst_y, 7);
    pulse_done();
    chk("R4 err sticky", status, 2);
    chk("R11 busy clear", status[0], 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule